// File: doc/BRIEF.md
# LED Driver Fault-Scan Host Sequencer

This block sits on the host side of a daisy chain of 16-channel serial constant-current LED sink drivers. It generates the chain's serial clock, serial data, latch strobe and output-enable signals from a fast system clock. A single scan command runs a complete open/short fault scan without any software help. First it sends the entry key pattern on OE and LE. It then shifts ones into every channel and latches them. Next it holds OE low for a programmed detection window. After that it clocks the per-channel result bits back in from the chain's serial output. Last, it sends the resume key so the drivers return to normal mode. The collected bits are presented as one parallel word together with a done pulse.

The same data path also serves ordinary display refreshes. A frame command shifts out a data word and strobes LE, so the host side needs only one engine for both jobs. The state machine has the following states:

- `ST_IDLE`
- `ST_KEY_ENTER`
- `ST_FILL`
- `ST_LATCH_ON`
- `ST_DETECT`
- `ST_READ`
- `ST_KEY_RESUME`
- `ST_LOAD`
- `ST_LATCH_FRM`

Transitions:

- IDLE goes to KEY_ENTER when a scan start arrives.
- IDLE goes to LOAD when a frame start arrives without a scan start.
- The scan path runs KEY_ENTER, FILL, LATCH_ON, DETECT, READ and KEY_RESUME, each after its last bit slot, and then returns to IDLE.
- DETECT ends when its window counter expires.
- The frame path runs LOAD, then LATCH_FRM, then returns to IDLE.

Every serial bit takes one slot of `2*HALF_DIV` system cycles. The serial clock is low for the first half of the slot and high for the second half. Data, OE and LE change only early in the low half.

Top module: `led_scan_seq`

## Requirements
- R1: After an accepted scan start, the first five rising edges of `drv_clk` see OE = 1,0,1,1,1 and LE = 0,0,0,1,0 in that order.
- R2: After the entry key, `16*N_DEV` clock pulses are sent with SDI = 1 and OE = 1. They are followed by one LE high pulse with no clock edge, so every channel latches a one.
- R3: OE is then held low for exactly `DET_CYCLES` system cycles with no `drv_clk` edge, and then returns high.
- R4: With OE high, `16*N_DEV` clock pulses are sent and `drv_sdo` is sampled just before each rising edge. The first bit sampled lands in `scan_word[16*N_DEV-1]` and the last in `scan_word[0]`, so bit index equals chain channel index.
- R5: After readback, five clock pulses carry OE = 1,0,1,1,1 with LE held low (the resume key). No entry key is issued again until a resume key has followed the previous one.
- R6: `drv_clk` stays high and low for at least `HALF_DIV` system cycles each. SDI, OE and LE are stable in the cycle where `drv_clk` rises. Every LE high pulse lasts at least two system cycles. `drv_clk` is low whenever the block is idle.
- R7: A frame start shifts `frame_data` out MSB first over `16*N_DEV` clock pulses with OE low, then pulses LE. Afterwards the chain holds `frame_data` with bit index equal to channel index, and no key pattern is sent.
- R8: `busy` rises the cycle after an accepted start and falls when the operation ends. `done` is a one-cycle pulse in that same cycle. `scan_word` changes only at the end of a scan.
- R9: `scan_start` and `frame_start` are ignored while busy. When both arrive together in idle, the scan is run.
- R10: In reset, `drv_clk`, `drv_sdi`, `drv_le`, `drv_oe`, `busy`, `done` and `scan_word` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_start | input | 1 | Request a full fault scan (one-cycle pulse) |
| frame_start | input | 1 | Request a display frame write (one-cycle pulse) |
| frame_data | input | 16*N_DEV | Frame word, bit index = chain channel index |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when an operation ends |
| scan_word | output | 16*N_DEV | Result bits of the last completed scan |
| drv_clk | output | 1 | Serial clock to the driver chain |
| drv_sdi | output | 1 | Serial data to the driver chain |
| drv_le | output | 1 | Latch strobe to the driver chain |
| drv_oe | output | 1 | Output enable to the chain, active low |
| drv_sdo | input | 1 | Serial data returned from the last driver in the chain |

## Verification
The hardest situation to reach from the ports is readback of a fault pattern that the sequencer itself must provoke. The chain only reports results after it has recognised a correct entry key, latched all ones and seen OE go low and then high again. The bench therefore drives `drv_sdo` from a behavioural chain model. This model decodes the five-edge key history and loads a chosen fault word only when OE rises in detection mode, so a wrong key, a missing fill or a misplaced window shows up as a wrong `scan_word`. The model also measures the longest OE-low run, counts clock edges inside it, and tracks the minimum clock and LE pulse widths.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_KEY_ENTER,
        ST_FILL,
        ST_LATCH_ON,
        ST_DETECT,
        ST_READ,
        ST_KEY_RESUME,
        ST_LOAD,
        ST_LATCH_FRM
    } seq_state_e;

    localparam int KEY_STEPS = 5;

    // OE level for each key step; the same for entry and resume keys
    function automatic logic key_oe(input logic [2:0] step);
        logic lvl;
        case (step)
            3'd1:    lvl = 1'b0;
            default: lvl = 1'b1;
        endcase
        return lvl;
    endfunction

    // LE level for each step of the entry key; the resume key keeps LE low
    function automatic logic key_le_enter(input logic [2:0] step);
        return (step == 3'd3);
    endfunction

endpackage

// File: rtl/led_scan_tick.sv
module led_scan_tick #(
    parameter int HALF_DIV = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic pulse_en,
    output logic ph_rise,
    output logic slot_end,
    output logic bit_clk
);
    localparam int SLOT = 2 * HALF_DIV;
    localparam int PW   = $clog2(SLOT);

    logic [PW-1:0] ph_q;

    assign slot_end = run && (ph_q == PW'(SLOT - 1));
    assign ph_rise  = run && (ph_q == PW'(HALF_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q    <= '0;
            bit_clk <= 1'b0;
        end else if (!run) begin
            ph_q    <= '0;
            bit_clk <= 1'b0;
        end else begin
            ph_q <= slot_end ? '0 : ph_q + 1'b1;
            if (ph_rise && pulse_en)
                bit_clk <= 1'b1;
            else if (slot_end)
                bit_clk <= 1'b0;
        end
    end

    // R6: the clock may rise only in the middle of a slot
    p_rise_mid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bit_clk) |-> (ph_q == PW'(HALF_DIV)));

endmodule

// File: rtl/led_scan_shreg.sv
module led_scan_shreg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         sin,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= load_val;
        else if (shift)
            q <= {q[W-2:0], sin};
    end
endmodule

// File: rtl/led_scan_seq.sv
module led_scan_seq
    import led_scan_pkg::*;
#(
    parameter int N_DEV      = 2,
    parameter int HALF_DIV   = 3,
    parameter int DET_CYCLES = 125
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scan_start,
    input  logic                  frame_start,
    input  logic [16*N_DEV-1:0]   frame_data,
    output logic                  busy,
    output logic                  done,
    output logic [16*N_DEV-1:0]   scan_word,
    output logic                  drv_clk,
    output logic                  drv_sdi,
    output logic                  drv_le,
    output logic                  drv_oe,
    input  logic                  drv_sdo
);
    localparam int W  = 16 * N_DEV;
    localparam int SW = $clog2(W + 1);
    localparam int DW = $clog2(DET_CYCLES + 1);

    seq_state_e     state_q, state_d;
    logic [SW-1:0]  slot_q;
    logic [DW-1:0]  det_q;
    logic           in_det_q;
    logic           done_q;
    logic [W-1:0]   scan_word_q;
    logic [W-1:0]   sr_q;
    logic           run, pulse_en, ph_rise, slot_end, last_slot;
    logic           sr_load, sr_shift, sr_in;
    logic [2:0]     key_idx;

    assign run      = (state_q != ST_IDLE) && (state_q != ST_DETECT);
    assign pulse_en = (state_q != ST_LATCH_ON) && (state_q != ST_LATCH_FRM);
    assign key_idx  = slot_q[2:0];
    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;
    assign scan_word = scan_word_q;

    led_scan_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .pulse_en (pulse_en),
        .ph_rise  (ph_rise),
        .slot_end (slot_end),
        .bit_clk  (drv_clk)
    );

    assign sr_load  = (state_q == ST_IDLE) && (state_d == ST_LOAD);
    assign sr_shift = ((state_q == ST_READ) && ph_rise) ||
                      ((state_q == ST_LOAD) && slot_end);
    assign sr_in    = (state_q == ST_READ) ? drv_sdo : 1'b0;

    led_scan_shreg #(.W(W)) u_sr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sr_load),
        .load_val (frame_data),
        .shift    (sr_shift),
        .sin      (sr_in),
        .q        (sr_q)
    );

    always_comb begin
        unique case (state_q)
            ST_KEY_ENTER, ST_KEY_RESUME: last_slot = (slot_q == SW'(KEY_STEPS - 1));
            ST_FILL, ST_READ, ST_LOAD:   last_slot = (slot_q == SW'(W - 1));
            default:                     last_slot = 1'b1;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (scan_start)       state_d = ST_KEY_ENTER;
                else if (frame_start) state_d = ST_LOAD;
            end
            ST_KEY_ENTER:  if (slot_end && last_slot) state_d = ST_FILL;
            ST_FILL:       if (slot_end && last_slot) state_d = ST_LATCH_ON;
            ST_LATCH_ON:   if (slot_end)              state_d = ST_DETECT;
            ST_DETECT:     if (det_q == DW'(DET_CYCLES - 1)) state_d = ST_READ;
            ST_READ:       if (slot_end && last_slot) state_d = ST_KEY_RESUME;
            ST_KEY_RESUME: if (slot_end && last_slot) state_d = ST_IDLE;
            ST_LOAD:       if (slot_end && last_slot) state_d = ST_LATCH_FRM;
            ST_LATCH_FRM:  if (slot_end)              state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // state register and its counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            slot_q      <= '0;
            det_q       <= '0;
            in_det_q    <= 1'b0;
            done_q      <= 1'b0;
            scan_word_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q)
                slot_q <= '0;
            else if (slot_end)
                slot_q <= slot_q + 1'b1;
            det_q  <= (state_q == ST_DETECT) ? det_q + 1'b1 : '0;
            done_q <= (state_q != ST_IDLE) && (state_d == ST_IDLE);
            if (state_q == ST_KEY_ENTER && state_d != ST_KEY_ENTER)
                in_det_q <= 1'b1;
            if (state_q == ST_KEY_RESUME && state_d == ST_IDLE) begin
                in_det_q    <= 1'b0;
                scan_word_q <= sr_q;
            end
        end
    end

    // registered pin levels
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_oe  <= 1'b0;
            drv_le  <= 1'b0;
            drv_sdi <= 1'b0;
        end else begin
            unique case (state_q)
                ST_KEY_ENTER: begin
                    drv_oe <= key_oe(key_idx); drv_le <= key_le_enter(key_idx); drv_sdi <= 1'b0;
                end
                ST_KEY_RESUME: begin
                    drv_oe <= key_oe(key_idx); drv_le <= 1'b0; drv_sdi <= 1'b0;
                end
                ST_FILL: begin
                    drv_oe <= 1'b1; drv_le <= 1'b0; drv_sdi <= 1'b1;
                end
                ST_LATCH_ON: begin
                    drv_oe <= 1'b1; drv_le <= 1'b1; drv_sdi <= 1'b0;
                end
                ST_READ: begin
                    drv_oe <= 1'b1; drv_le <= 1'b0; drv_sdi <= 1'b0;
                end
                ST_LOAD: begin
                    drv_oe <= 1'b0; drv_le <= 1'b0; drv_sdi <= sr_q[W-1];
                end
                ST_LATCH_FRM: begin
                    drv_oe <= 1'b0; drv_le <= 1'b1; drv_sdi <= 1'b0;
                end
                default: begin
                    drv_oe <= 1'b0; drv_le <= 1'b0; drv_sdi <= 1'b0;
                end
            endcase
        end
    end

    // R6: pin levels never move in the cycle the serial clock rises
    p_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_clk) |-> ($stable(drv_sdi) && $stable(drv_oe) && $stable(drv_le)));

    // R6: no serial clock while idle
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !drv_clk);

    // R3: the detection window carries no clock
    p_window_noclk_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DETECT) |-> !drv_clk);

    // R5: an entry key never follows another entry key without a resume
    p_no_double_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && state_d == ST_KEY_ENTER) |-> !in_det_q);

    // R8: done arrives together with the end of busy
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9: a frame in flight is not diverted by a new request
    p_frame_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD) |=> (state_q == ST_LOAD || state_q == ST_LATCH_FRM));

endmodule

// File: tb/led_scan_seq_tb.sv
module led_scan_seq_tb;
    localparam int N_DEV = 2;
    localparam int HALF  = 3;
    localparam int DET   = 125;
    localparam int W     = 16 * N_DEV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scan_start = 1'b0;
    logic frame_start = 1'b0;
    logic [W-1:0] frame_data = '0;
    logic busy, done, drv_clk, drv_sdi, drv_le, drv_oe, drv_sdo;
    logic [W-1:0] scan_word;

    always #4 clk = ~clk;

    led_scan_seq #(.N_DEV(N_DEV), .HALF_DIV(HALF), .DET_CYCLES(DET)) u_dut (
        .clk(clk), .rst_n(rst_n), .scan_start(scan_start), .frame_start(frame_start),
        .frame_data(frame_data), .busy(busy), .done(done), .scan_word(scan_word),
        .drv_clk(drv_clk), .drv_sdi(drv_sdi), .drv_le(drv_le), .drv_oe(drv_oe),
        .drv_sdo(drv_sdo)
    );

    // ---------------- behavioural driver chain ----------------
    logic [W-1:0] dev_sr = '0, latch = '0, fault_pat = '0;
    logic [4:0]   h_oe = '0, h_le = '0;
    logic         det_mode = 1'b0, clk_d = 1'b0, oe_d = 1'b0, le_d = 1'b0;
    logic         ones_ok = 1'b0;
    int n_enter = 0, n_resume = 0;
    int low_run = 0, run_rises = 0, best_len = 0, best_rises = 0;
    int lvl_run = 0, min_hi = 1000, min_lo = 1000, le_run = 0, min_le = 1000;

    assign drv_sdo = dev_sr[W-1];

    always @(posedge clk) begin
        logic [4:0] no, nl;
        clk_d <= drv_clk;
        oe_d  <= drv_oe;
        le_d  <= drv_le;
        if (drv_clk && !clk_d) begin
            no = {h_oe[3:0], drv_oe};
            nl = {h_le[3:0], drv_le};
            h_oe <= no;
            h_le <= nl;
            dev_sr <= {dev_sr[W-2:0], drv_sdi};
            if (!det_mode && no == 5'b10111 && nl == 5'b00010) begin
                det_mode <= 1'b1; n_enter <= n_enter + 1;
            end else if (det_mode && no == 5'b10111 && nl == 5'b00000) begin
                det_mode <= 1'b0; n_resume <= n_resume + 1;
            end
        end else if (drv_oe && !oe_d && det_mode) begin
            dev_sr <= fault_pat;
        end
        if (drv_le) latch <= dev_sr;
        if (!drv_oe && oe_d && det_mode) ones_ok <= (latch == '1);
        // OE low runs in detection mode
        if (det_mode && !drv_oe) begin
            low_run <= low_run + 1;
            if (drv_clk && !clk_d) run_rises <= run_rises + 1;
        end else begin
            if (det_mode && drv_oe && !oe_d && low_run > best_len) begin
                best_len <= low_run; best_rises <= run_rises;
            end
            low_run <= 0; run_rises <= 0;
        end
        // clock and LE widths
        if (rst_n) begin
            if (drv_clk != clk_d) begin
                if (clk_d && lvl_run < min_hi) min_hi <= lvl_run;
                if (!clk_d && lvl_run < min_lo && lvl_run > 0) min_lo <= lvl_run;
                lvl_run <= 1;
            end else lvl_run <= lvl_run + 1;
            if (drv_le) le_run <= le_run + 1;
            else begin
                if (le_d && le_run < min_le) min_le <= le_run;
                le_run <= 0;
            end
        end
    end

    // ---------------- checking ----------------
    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 4000 && !seen; i++) begin
            @(negedge clk);
            if (done) seen = 1'b1;
        end
    endtask

    localparam logic [W-1:0] PAT [4] = '{32'h0000_0000, 32'h8000_0001, 32'hA5C3_0FF0, 32'hFFFF_FFFF};
    localparam logic [W-1:0] FRM [4] = '{32'h1234_5678, 32'hFFFF_0000, 32'h0000_0001, 32'h8000_0000};

    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            chk(1'b0, "watchdog", 64'(cyc), 64'd150000);
            finish_run();
        end
    end

    initial begin
        bit seen;
        int e0, r0;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk({drv_clk, drv_sdi, drv_le, drv_oe, busy, done} == 6'b0, "R10 pins in reset",
            64'({drv_clk, drv_sdi, drv_le, drv_oe, busy, done}), 64'd0);
        chk(scan_word == '0, "R10 scan_word in reset", 64'(scan_word), 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int v = 0; v < 4; v++) begin
            // ---- scan ----
            fault_pat = PAT[v];
            best_len = 0; best_rises = 0;
            e0 = n_enter; r0 = n_resume;
            scan_start = 1'b1;
            @(negedge clk);
            scan_start = 1'b0;
            chk(busy == 1'b1, "R8 busy after scan start", 64'(busy), 64'd1);
            wait_done(seen);
            chk(seen, "R8 scan done pulse", 64'(seen), 64'd1);
            @(negedge clk);
            chk(done == 1'b0, "R8 done one cycle", 64'(done), 64'd0);
            chk(busy == 1'b0, "R8 busy released", 64'(busy), 64'd0);
            repeat (2) @(negedge clk);
            chk(scan_word == PAT[v], "R4 readback word", 64'(scan_word), 64'(PAT[v]));
            chk(n_enter == e0 + 1, "R1 entry key recognised", 64'(n_enter), 64'(e0 + 1));
            chk(ones_ok, "R2 all ones latched", 64'(ones_ok), 64'd1);
            chk(best_len == DET, "R3 window length", 64'(best_len), 64'(DET));
            chk(best_rises == 0, "R3 no clock in window", 64'(best_rises), 64'd0);
            chk(n_resume == r0 + 1 && !det_mode, "R5 resume key recognised",
                64'(n_resume), 64'(r0 + 1));
            // ---- frame ----
            e0 = n_enter;
            frame_data = FRM[v];
            frame_start = 1'b1;
            @(negedge clk);
            frame_start = 1'b0;
            frame_data = '0;
            wait_done(seen);
            chk(seen, "R8 frame done pulse", 64'(seen), 64'd1);
            repeat (3) @(negedge clk);
            chk(latch == FRM[v], "R7 frame latched", 64'(latch), 64'(FRM[v]));
            chk(n_enter == e0 && !det_mode, "R7 no key on frame", 64'(n_enter), 64'(e0));
            chk(scan_word == PAT[v], "R8 scan_word kept on frame", 64'(scan_word), 64'(PAT[v]));
        end

        // R9: scan request during a frame is ignored
        e0 = n_enter;
        frame_data = 32'h0F0F_F0F0;
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        repeat (40) @(negedge clk);
        scan_start = 1'b1;
        @(negedge clk);
        scan_start = 1'b0;
        wait_done(seen);
        repeat (20) @(negedge clk);
        chk(busy == 1'b0, "R9 no scan after ignored start", 64'(busy), 64'd0);
        chk(n_enter == e0, "R9 no key after ignored start", 64'(n_enter), 64'(e0));
        chk(latch == 32'h0F0F_F0F0, "R9 frame intact", 64'(latch), 64'h0F0FF0F0);

        // R9: frame request during a scan is ignored; simultaneous starts give a scan
        fault_pat = 32'h0000_FFFF;
        e0 = n_enter;
        frame_data = 32'h1111_1111;
        scan_start = 1'b1; frame_start = 1'b1;
        @(negedge clk);
        scan_start = 1'b0; frame_start = 1'b0;
        repeat (100) @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        wait_done(seen);
        repeat (20) @(negedge clk);
        chk(n_enter == e0 + 1, "R9 scan wins tie", 64'(n_enter), 64'(e0 + 1));
        chk(scan_word == 32'h0000_FFFF, "R9 scan result", 64'(scan_word), 64'h0000FFFF);
        chk(busy == 1'b0, "R9 no frame after ignored start", 64'(busy), 64'd0);
        chk(latch == '1, "R9 latch still ones", 64'(latch), 64'hFFFFFFFF);

        // R6 pulse widths
        chk(min_hi >= HALF, "R6 clock high width", 64'(min_hi), 64'(HALF));
        chk(min_lo >= HALF, "R6 clock low width", 64'(min_lo), 64'(HALF));
        chk(min_le >= 2, "R6 LE pulse width", 64'(min_le), 64'd2);
        chk(drv_clk == 1'b0, "R6 clock low when idle", 64'(drv_clk), 64'd0);

        finish_run();
    end
endmodule